// File: doc/BRIEF.md
# Vector Element Widening Unit

This block widens packed narrow elements held in one or two source vectors into elements of twice the width. Each source vector is cut into a lower half and an upper half of its narrow elements, and each half fills a destination vector of its own. Element order inside a half is kept. The element in the high bits is filled from the narrow element's top bit when sign extension is chosen, and with zeros when zero extension is chosen.

A size code picks the widened element width: 16, 32 or 64 bits. The narrow width is half of that. A variant select chooses one of two forms. The pair form reads one source and writes two destinations. The quad form reads two sources and writes four destinations. The unit also turns the encoded register fields into aligned register numbers for the destination group and the source group. A request is taken on a clock edge where `start` and `enable` are both high. All results, together with the register numbers, appear one cycle later, when `done` pulses. A request that uses the reserved size code pulses `undef` instead, and nothing is written.

Top module: `vec_widen_unit`

## Requirements
- R1: The widened element width is 8 << sizeCode (sizeCode 1, 2, 3 give 16, 32, 64 bits). Element e of dstVec0 is narrow element e of srcVec0, sign-extended. The count of elements per destination is VL divided by the widened width.
- R2: Element e of dstVec1 is narrow element (VL / widened width) + e of srcVec0, so dstVec1 takes the upper half of the narrow elements.
- R3: When fourReg=1, dstVec2 and dstVec3 are filled from the lower and upper halves of srcVec1 in the same way. When fourReg=0, dstVec2 and dstVec3 keep their previous values.
- R4: When zeroExt=1, the widening fills the high bits with zeros instead of copies of the narrow sign bit.
- R5: A request with sizeCode 00 pulses undef high for one cycle, one cycle after the request. done stays low, and no destination vector, dstBase or srcBase changes.
- R6: While enable is low, start is ignored. done and undef stay low, and all outputs keep their values.
- R7: For an accepted request, the destinations and done are updated at the first rising edge after the request edge. done is high for one cycle for each request and stays high when requests come back to back.
- R8: dstBase equals dstField*2 when fourReg=0, and dstField[2:0]*4 when fourReg=1. The destination group therefore spans dstBase to dstBase+1, or dstBase to dstBase+3.
- R9: srcBase equals srcField when fourReg=0, and srcField[3:0]*2 when fourReg=1. In the quad form the second source is srcBase+1.
- R10: After reset, done and undef are 0, and every destination vector, dstBase and srcBase are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| enable | input | 1 | Unit enable; a request is taken only while it is high |
| sizeCode | input | 2 | Widened element size code, 00 reserved |
| fourReg | input | 1 | 1 selects the quad form (two sources, four destinations) |
| zeroExt | input | 1 | 1 selects zero extension, 0 selects sign extension |
| dstField | input | REG_W-1 | Encoded destination group field |
| srcField | input | REG_W | Encoded source field |
| srcVec0 | input | VL | First source vector |
| srcVec1 | input | VL | Second source vector (quad form only) |
| dstVec0 | output | VL | Destination 0 |
| dstVec1 | output | VL | Destination 1 |
| dstVec2 | output | VL | Destination 2 (quad form) |
| dstVec3 | output | VL | Destination 3 (quad form) |
| dstBase | output | REG_W | First destination register number |
| srcBase | output | REG_W | First source register number |
| done | output | 1 | One-cycle pulse when results are written |
| undef | output | 1 | One-cycle pulse for a reserved size request |

## Verification
Two things can land in the same clock edge: the result write of one accepted request, and the capture of the next request, which may use the reserved size. The bench keeps start high for two cycles, first with a valid quad request and then with sizeCode 00. It expects done on the first following cycle, with the quad results. On the next cycle it expects undef with done low, and the quad results still held. The same stimulus goes to a VL=128 instance and a VL=256 instance. The expected vectors come from a bit-level reference loop.

// File: rtl/widen_pkg.sv
package widen_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture results and register numbers
    logic wrUpper;  // also write destinations 2 and 3
  } widenStrobe_t;

  localparam logic [1:0] SIZE_RESERVED = 2'b00;
endpackage

// File: rtl/widen_ctrl.sv
module widen_ctrl
  import widen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         enable,
  input  logic [1:0]   sizeCode,
  input  logic         fourReg,
  output widenStrobe_t strobe,
  output logic         done,
  output logic         undef
);
  logic accept;
  logic reserved;

  always_comb begin
    accept         = start & enable;
    reserved       = (sizeCode == SIZE_RESERVED);
    strobe.load    = accept & ~reserved;
    strobe.wrUpper = fourReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done  <= 1'b0;
      undef <= 1'b0;
    end else begin
      done  <= strobe.load;
      undef <= accept & reserved;
    end
  end
endmodule

// File: rtl/widen_datapath.sv
module widen_datapath
  import widen_pkg::*;
#(
  parameter int VL    = 128,
  parameter int REG_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  widenStrobe_t       strobe,
  input  logic [1:0]         sizeCode,
  input  logic               zeroExt,
  input  logic               fourReg,
  input  logic [REG_W-2:0]   dstField,
  input  logic [REG_W-1:0]   srcField,
  input  logic [VL-1:0]      srcLo,
  input  logic [VL-1:0]      srcHi,
  output logic [3:0][VL-1:0] dstVec,
  output logic [REG_W-1:0]   dstBase,
  output logic [REG_W-1:0]   srcBase
);
  localparam int NUM_DST = 4;

  logic [NUM_DST-1:0][VL-1:0] wideSel;
  logic [REG_W-1:0]           dstBaseNext;
  logic [REG_W-1:0]           srcBaseNext;

  // widening network: one candidate per size code, per destination
  for (genvar q = 0; q < NUM_DST; q++) begin : g_dst
    logic [VL-1:0]      srcPick;
    logic [3:1][VL-1:0] cand;

    if (q >= 2) begin : g_hi
      assign srcPick = srcHi;
    end else begin : g_lo
      assign srcPick = srcLo;
    end

    for (genvar s = 1; s < 4; s++) begin : g_sz
      localparam int ESZ  = 8 << s;
      localparam int HSZ  = ESZ / 2;
      localparam int NEL  = VL / ESZ;
      localparam int BASE = (q % 2) * NEL * HSZ;
      for (genvar e = 0; e < NEL; e++) begin : g_el
        logic [HSZ-1:0] narrow;
        logic           fill;
        assign narrow = srcPick[BASE + e*HSZ +: HSZ];
        assign fill   = ~zeroExt & narrow[HSZ-1];
        assign cand[s][e*ESZ +: ESZ] = {{HSZ{fill}}, narrow};
      end
    end

    always_comb begin
      case (sizeCode)
        2'd1:    wideSel[q] = cand[1];
        2'd2:    wideSel[q] = cand[2];
        2'd3:    wideSel[q] = cand[3];
        default: wideSel[q] = '0;
      endcase
    end
  end

  // aligned register numbering
  always_comb begin
    if (fourReg) begin
      dstBaseNext = {dstField[REG_W-3:0], 2'b00};
      srcBaseNext = {srcField[REG_W-2:0], 1'b0};
    end else begin
      dstBaseNext = {dstField, 1'b0};
      srcBaseNext = srcField;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstVec  <= '0;
      dstBase <= '0;
      srcBase <= '0;
    end else if (strobe.load) begin
      dstVec[0] <= wideSel[0];
      dstVec[1] <= wideSel[1];
      if (strobe.wrUpper) begin
        dstVec[2] <= wideSel[2];
        dstVec[3] <= wideSel[3];
      end
      dstBase <= dstBaseNext;
      srcBase <= srcBaseNext;
    end
  end
endmodule

// File: rtl/vec_widen_unit.sv
module vec_widen_unit
  import widen_pkg::*;
#(
  parameter int VL    = 128,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             enable,
  input  logic [1:0]       sizeCode,
  input  logic             fourReg,
  input  logic             zeroExt,
  input  logic [REG_W-2:0] dstField,
  input  logic [REG_W-1:0] srcField,
  input  logic [VL-1:0]    srcVec0,
  input  logic [VL-1:0]    srcVec1,
  output logic [VL-1:0]    dstVec0,
  output logic [VL-1:0]    dstVec1,
  output logic [VL-1:0]    dstVec2,
  output logic [VL-1:0]    dstVec3,
  output logic [REG_W-1:0] dstBase,
  output logic [REG_W-1:0] srcBase,
  output logic             done,
  output logic             undef
);
  widenStrobe_t       strobe;
  logic [3:0][VL-1:0] dstVec;

  widen_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .enable   (enable),
    .sizeCode (sizeCode),
    .fourReg  (fourReg),
    .strobe   (strobe),
    .done     (done),
    .undef    (undef)
  );

  widen_datapath #(.VL(VL), .REG_W(REG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sizeCode (sizeCode),
    .zeroExt  (zeroExt),
    .fourReg  (fourReg),
    .dstField (dstField),
    .srcField (srcField),
    .srcLo    (srcVec0),
    .srcHi    (srcVec1),
    .dstVec   (dstVec),
    .dstBase  (dstBase),
    .srcBase  (srcBase)
  );

  assign dstVec0 = dstVec[0];
  assign dstVec1 = dstVec[1];
  assign dstVec2 = dstVec[2];
  assign dstVec3 = dstVec[3];
endmodule

// File: rtl/widen_chk.sv
module widen_chk #(
  parameter int VL    = 128,
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             enable,
  input logic [1:0]       sizeCode,
  input logic             fourReg,
  input logic [VL-1:0]    dstVec0,
  input logic [VL-1:0]    dstVec2,
  input logic [VL-1:0]    dstVec3,
  input logic [REG_W-1:0] dstBase,
  input logic [REG_W-1:0] srcBase,
  input logic             done,
  input logic             undef
);
  // R5
  undef_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    undef |-> !done);

  // R5
  undef_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    undef |-> ($stable(dstVec0) && $stable(dstBase) && $stable(srcBase)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(dstVec0) && $stable(dstVec2) && $stable(dstBase)));

  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start && enable && (sizeCode != 2'b00)));

  // R3
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(fourReg)) |-> ($stable(dstVec2) && $stable(dstVec3)));

  // R8
  quad_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(fourReg)) |-> (dstBase[1:0] == 2'b00));

  // R9
  src_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(fourReg)) |-> (srcBase[0] == 1'b0));
endmodule

bind vec_widen_unit widen_chk #(.VL(VL), .REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .enable   (enable),
  .sizeCode (sizeCode),
  .fourReg  (fourReg),
  .dstVec0  (dstVec0),
  .dstVec2  (dstVec2),
  .dstVec3  (dstVec3),
  .dstBase  (dstBase),
  .srcBase  (srcBase),
  .done     (done),
  .undef    (undef)
);

// File: tb/vec_widen_unit_tb.sv
module vec_widen_unit_tb;
  localparam int NV = 10;

  typedef struct packed {
    logic [1:0] sz;
    logic       four;
    logic       zx;
    logic [3:0] df;
    logic [4:0] sf;
    logic [1:0] pat;   // 0 random, 1 most-negative, 2 all-ones, 3 zero
    logic [4:0] expD;
    logic [4:0] expS;
  } vec_t;

  localparam vec_t TABLE [NV] = '{
    '{2'd1, 1'b0, 1'b0, 4'h5, 5'h11, 2'd0, 5'd10, 5'd17},
    '{2'd1, 1'b1, 1'b0, 4'hB, 5'h1D, 2'd1, 5'd12, 5'd26},
    '{2'd2, 1'b0, 1'b0, 4'h7, 5'h03, 2'd2, 5'd14, 5'd3},
    '{2'd2, 1'b1, 1'b1, 4'h2, 5'h06, 2'd0, 5'd8,  5'd12},
    '{2'd3, 1'b0, 1'b0, 4'hF, 5'h1F, 2'd1, 5'd30, 5'd31},
    '{2'd3, 1'b1, 1'b0, 4'h1, 5'h04, 2'd3, 5'd4,  5'd8},
    '{2'd1, 1'b0, 1'b1, 4'h0, 5'h00, 2'd2, 5'd0,  5'd0},
    '{2'd3, 1'b1, 1'b1, 4'h7, 5'h0F, 2'd0, 5'd28, 5'd30},
    '{2'd2, 1'b1, 1'b0, 4'h3, 5'h09, 2'd1, 5'd12, 5'd18},
    '{2'd1, 1'b1, 1'b1, 4'h6, 5'h02, 2'd2, 5'd24, 5'd4}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic enable = 1'b0;
  logic [1:0] sizeCode = 2'd0;
  logic fourReg = 1'b0;
  logic zeroExt = 1'b0;
  logic [3:0] dstField = '0;
  logic [4:0] srcField = '0;
  logic [255:0] src0 = '0;
  logic [255:0] src1 = '0;

  logic [127:0] a0, a1, a2, a3;
  logic [255:0] b0, b1, b2, b3;
  logic [4:0] dBaseA, sBaseA, dBaseB, sBaseB;
  logic doneA, undefA, doneB, undefB;

  int nChk = 0;
  int nFail = 0;
  logic [255:0] expV [2][4];
  logic [4:0] expDB = '0;
  logic [4:0] expSB = '0;

  always #2 clk = ~clk;

  vec_widen_unit #(.VL(128), .REG_W(5)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .enable(enable), .sizeCode(sizeCode),
    .fourReg(fourReg), .zeroExt(zeroExt), .dstField(dstField), .srcField(srcField),
    .srcVec0(src0[127:0]), .srcVec1(src1[127:0]),
    .dstVec0(a0), .dstVec1(a1), .dstVec2(a2), .dstVec3(a3),
    .dstBase(dBaseA), .srcBase(sBaseA), .done(doneA), .undef(undefA)
  );

  vec_widen_unit #(.VL(256), .REG_W(5)) u_dut256 (
    .clk(clk), .rstN(rstN), .start(start), .enable(enable), .sizeCode(sizeCode),
    .fourReg(fourReg), .zeroExt(zeroExt), .dstField(dstField), .srcField(srcField),
    .srcVec0(src0), .srcVec1(src1),
    .dstVec0(b0), .dstVec1(b1), .dstVec2(b2), .dstVec3(b3),
    .dstBase(dBaseB), .srcBase(sBaseB), .done(doneB), .undef(undefB)
  );

  function automatic logic [255:0] outOf(int k, int q);
    if (k == 0) begin
      case (q)
        0: return {128'd0, a0};
        1: return {128'd0, a1};
        2: return {128'd0, a2};
        default: return {128'd0, a3};
      endcase
    end
    case (q)
      0: return b0;
      1: return b1;
      2: return b2;
      default: return b3;
    endcase
  endfunction

  // bit-level reference widening
  function automatic logic [255:0] refWiden(logic [255:0] src, int vl, int sz, int half, bit zx);
    logic [255:0] r;
    int esz, hsz, nel, base;
    r = '0;
    esz = 8 << sz;
    hsz = esz / 2;
    nel = vl / esz;
    for (int e = 0; e < nel; e++) begin
      base = half * nel * hsz + e * hsz;
      for (int b = 0; b < esz; b++) begin
        if (b < hsz) r[e*esz + b] = src[base + b];
        else         r[e*esz + b] = zx ? 1'b0 : src[base + hsz - 1];
      end
    end
    return r;
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic fillSrc(int sz, int pat);
    int h;
    h = (sz == 0) ? 8 : (4 << sz);
    for (int w = 0; w < 8; w++) begin
      src0[w*32 +: 32] = $urandom;
      src1[w*32 +: 32] = $urandom;
    end
    if (pat != 0) begin
      for (int b = 0; b < 256; b++) begin
        case (pat)
          1:       begin src0[b] = ((b % h) == h - 1); src1[b] = ((b % h) == h - 1); end
          2:       begin src0[b] = 1'b1; src1[b] = 1'b1; end
          default: begin src0[b] = 1'b0; src1[b] = 1'b0; end
        endcase
      end
    end
  endtask

  task automatic checkAll(string tag);
    for (int k = 0; k < 2; k++)
      for (int q = 0; q < 4; q++)
        chk(tag, outOf(k, q), expV[k][q]);
    chk({tag, " dstBase R8"}, {251'd0, dBaseA}, {251'd0, expDB});
    chk({tag, " srcBase R9"}, {251'd0, sBaseA}, {251'd0, expSB});
    chk({tag, " dstBase256 R8"}, {251'd0, dBaseB}, {251'd0, expDB});
  endtask

  task automatic updateExp(int sz, bit four, bit zx);
    for (int k = 0; k < 2; k++)
      for (int q = 0; q < 4; q++)
        if (q < 2 || four)
          expV[k][q] = refWiden(q >= 2 ? src1 : src0, k == 0 ? 128 : 256, sz, q % 2, zx);
  endtask

  task automatic runOp(int sz, bit four, bit zx, logic [3:0] df, logic [4:0] sf,
                       int pat, bit en, logic [4:0] eD, logic [4:0] eS, string tag);
    bit valid;
    fillSrc(sz, pat);
    sizeCode = sz[1:0];
    fourReg = four;
    zeroExt = zx;
    dstField = df;
    srcField = sf;
    enable = en;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    valid = en && (sz != 0);
    if (valid) begin
      updateExp(sz, four, zx);
      expDB = eD;
      expSB = eS;
    end
    chk({tag, " done R7"}, {255'd0, doneA}, {255'd0, valid});
    chk({tag, " done256 R7"}, {255'd0, doneB}, {255'd0, valid});
    chk({tag, " undef R5/R6"}, {255'd0, undefA}, {255'd0, en && (sz == 0)});
    checkAll(tag);
    @(negedge clk);
    chk({tag, " done pulse R7"}, {254'd0, doneA, undefA}, 256'd0);
    enable = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 2; k++)
      for (int q = 0; q < 4; q++)
        expV[k][q] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 done/undef", {252'd0, doneA, undefA, doneB, undefB}, 256'd0);
    checkAll("R10 reset");

    // table walk: R1 R2 R3 R4 R8 R9
    for (int i = 0; i < NV; i++)
      runOp(TABLE[i].sz, TABLE[i].four, TABLE[i].zx, TABLE[i].df, TABLE[i].sf,
            TABLE[i].pat, 1'b1, TABLE[i].expD, TABLE[i].expS,
            TABLE[i].zx ? "R4 widen" : (TABLE[i].four ? "R3 widen" : "R1/R2 widen"));

    // R5 reserved size: nothing written
    runOp(0, 1'b1, 1'b0, 4'h9, 5'h13, 0, 1'b1, 5'd0, 5'd0, "R5 reserved");
    // R6 enable low with valid and reserved sizes
    runOp(2, 1'b1, 1'b0, 4'h4, 5'h05, 0, 1'b0, 5'd0, 5'd0, "R6 disabled");
    runOp(0, 1'b0, 1'b0, 4'h4, 5'h05, 2, 1'b0, 5'd0, 5'd0, "R6 disabled reserved");
    // R3 pair form keeps upper destinations after a quad op
    runOp(3, 1'b1, 1'b0, 4'h2, 5'h0A, 1, 1'b1, 5'd8, 5'd20, "R3 quad before pair");
    runOp(1, 1'b0, 1'b0, 4'hC, 5'h15, 2, 1'b1, 5'd24, 5'd21, "R3 pair keeps upper");

    // back to back: valid quad request then reserved request
    fillSrc(2, 0);
    sizeCode = 2'd2; fourReg = 1'b1; zeroExt = 1'b0;
    dstField = 4'h1; srcField = 5'h02; enable = 1'b1; start = 1'b1;
    @(negedge clk);
    updateExp(2, 1'b1, 1'b0);
    expDB = 5'd4; expSB = 5'd4;
    sizeCode = 2'd0; dstField = 4'hE; srcField = 5'h1B;
    src0 = ~src0;
    chk("R7 b2b done", {254'd0, doneA, undefA}, {254'd0, 2'b10});
    checkAll("R7 b2b first");
    @(negedge clk);
    start = 1'b0; enable = 1'b0;
    chk("R5 b2b undef", {254'd0, doneA, undefA}, {254'd0, 2'b01});
    checkAll("R5 b2b held");
    @(negedge clk);
    chk("R7 b2b idle", {254'd0, doneA, undefA}, 256'd0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nChk++;
    nFail++;
    $display("FAIL watchdog R7 act=hung exp=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule